// File: doc/BRIEF.md
# Edge Timestamping Engine with Event FIFO

The engine watches a bank of input lines, grouped into slices of 32 lines. Each slice has its own enable mask. When any enabled line of a slice changes level, the block records one event. The event holds the level of every enabled line of that slice before and after the change, the slice number, and the value of a free-running 64-bit timestamp counter. Events go into a FIFO. Software reads them one at a time through a small register window.

The timestamp counter advances once per clock. On a 31.25 MHz clock each tick is 32 ns. Software identifies the lines that moved by taking the XOR of the two snapshots. For each such line, the bit in the newer snapshot gives the edge direction: 1 means rising and 0 means falling. Software then removes the head event with a pop command. A level interrupt tells software when enough events are waiting.

Top module: `ets_engine`

## Requirements
- R1: After reset, the control word (0x00) reads 0x0000_0100: both enables are clear and the threshold in bits 15:8 is 1. Status (0x20) reads 0, every slice mask reads 0, and `irq_o` is low.
- R2: Take global enable as control bit 0. When it is set and an enabled line changes, exactly one event is added. The occupancy in status bits 15:8 rises on the fourth rising clock edge after the input change, and not on the third.
- R3: The mask for slice N is at 0x40 + 0x20*N, with one bit per line. A line whose mask bit is clear never creates an event. That line's bit reads 0 in both snapshots.
- R4: While control bit 0 is clear, line changes create no events. Re-enabling afterwards does not create an event for the changes missed while disabled.
- R5: Several enabled lines of one slice that change on the same cycle produce a single event. The head registers return: the slice number in source (0x0C) bits 23:16, the new snapshot at 0x10, and the old snapshot at 0x14.
- R6: Suppose changes hit several slices on the same cycle. The lowest-numbered slice is queued first, then the others in rising slice order. Every one of these events carries the same timestamp.
- R7: The timestamp is read as high word (0x04) and low word (0x08) of a counter that advances once per clock. The timestamps of two events differ by the number of cycles between the input changes that caused them.
- R8: Writing exactly 1 to the command register (0x1C) removes the head event. Writing any other value does nothing, and a pop on an empty FIFO also does nothing.
- R9: When the FIFO is empty, the timestamp, source and snapshot registers read 0.
- R10: When an event arrives and the FIFO is full (16 entries by default), the event is dropped and status bit 0 is set. That flag stays set until software writes 1 to status bit 0. Writing 0 there leaves it set.
- R11: `irq_o` is high exactly while control bit 0, control bit 1 (interrupt enable) and the condition occupancy >= threshold are all true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the timestamp tick |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lines_i | input | NUM_SLICES*32 | Monitored lines; bit slice*32+k is line k of that slice |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Level interrupt on occupancy threshold |

## Verification
Most internal faults show up at the status register within four or five cycles of a line change. A lost or duplicated pending flag makes the occupancy wrong. A wrong change reference either creates a spurious event after re-enable or misses a real one. Faults in the arbiter or snapshot path show up at the head registers: the wrong slice is reported first, the timestamps of simultaneous events differ, or unmasked bits leak into the snapshots. FIFO pointer and count faults appear when the FIFO is filled to its limit and drained, as a wrong occupancy, a missing overflow flag, or non-zero head values once the FIFO is empty.

// File: rtl/ets_pkg.sv
package ets_pkg;
  localparam int LANES = 32;
  localparam int SID_W = 8;
  localparam int TS_W  = 64;

  typedef struct packed {
    logic [TS_W-1:0]  ts;
    logic [SID_W-1:0] sid;
    logic [LANES-1:0] prev;
    logic [LANES-1:0] cur;
  } ets_entry_t;
endpackage

// File: rtl/ets_capture.sv
module ets_capture
  import ets_pkg::*;
#(
  parameter int NUM_SLICES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        glb_en_i,
  input  logic [NUM_SLICES*LANES-1:0] lines_i,
  input  logic [NUM_SLICES*LANES-1:0] mask_i,
  input  logic [TS_W-1:0]             ts_i,
  input  logic                        full_i,
  output logic                        push_o,
  output logic                        drop_o,
  output ets_entry_t                  entry_o
);
  localparam int NL = NUM_SLICES * LANES;

  logic [NL-1:0] sync1_q, sync2_q;
  logic [NUM_SLICES-1:0] hit, pend_w, grant;
  logic [NUM_SLICES-1:0][TS_W-1:0]  pts;
  logic [NUM_SLICES-1:0][LANES-1:0] pprev, pcur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= lines_i;
      sync2_q <= sync1_q;
    end
  end

  for (genvar n = 0; n < NUM_SLICES; n++) begin : g_slice
    logic [LANES-1:0] ref_q, ref_d, now_w, msk_w, prev_q, cur_q;
    logic [TS_W-1:0]  ts_q;
    logic             pend_q, pend_d;

    assign now_w    = sync2_q[n*LANES +: LANES];
    assign msk_w    = mask_i[n*LANES +: LANES];
    assign hit[n]   = glb_en_i && !pend_q && (((now_w ^ ref_q) & msk_w) != '0);
    assign pend_w[n] = pend_q;
    assign pts[n]   = ts_q;
    assign pprev[n] = prev_q;
    assign pcur[n]  = cur_q;

    // reference holds while an event waits, so later edges are reported next
    always_comb begin
      ref_d  = pend_q ? ref_q : now_w;
      pend_d = (pend_q && !grant[n]) || hit[n];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ref_q  <= '0;
        pend_q <= 1'b0;
        ts_q   <= '0;
        prev_q <= '0;
        cur_q  <= '0;
      end else begin
        ref_q  <= ref_d;
        pend_q <= pend_d;
        if (hit[n]) begin
          ts_q   <= ts_i;
          prev_q <= ref_q & msk_w;
          cur_q  <= now_w & msk_w;
        end
      end
    end
  end

  always_comb begin
    grant = '0;
    for (int i = 0; i < NUM_SLICES; i++) begin
      if (pend_w[i] && (grant == '0)) grant[i] = 1'b1;
    end
  end

  always_comb begin
    entry_o = '0;
    for (int i = 0; i < NUM_SLICES; i++) begin
      if (grant[i]) begin
        entry_o.ts   = pts[i];
        entry_o.sid  = SID_W'(i);
        entry_o.prev = pprev[i];
        entry_o.cur  = pcur[i];
      end
    end
  end

  assign push_o = (grant != '0) && !full_i;
  assign drop_o = (grant != '0) && full_i;

  // R5
  chg_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> ((entry_o.prev ^ entry_o.cur) != '0));
endmodule

// File: rtl/ets_fifo.sv
module ets_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic [W-1:0]               din_i,
  output logic [W-1:0]               dout_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_wr, do_rd;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_wr   = push_i && !full_o;
  assign do_rd   = pop_i && !empty_o;
  assign dout_o  = mem[rptr_q];
  assign count_o = cnt_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (do_wr) wptr_d = (wptr_q == PTR_W'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
    if (do_rd) rptr_d = (rptr_q == PTR_W'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
    cnt_d = cnt_q + CNT_W'(do_wr) - CNT_W'(do_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q] <= din_i;
  end

  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R8
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !empty_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R2
  push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/ets_engine.sv
module ets_engine
  import ets_pkg::*;
#(
  parameter int NUM_SLICES = 2,
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLICES*LANES-1:0] lines_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic                        bus_wr_i,
  input  logic [31:0]                 bus_wdata_i,
  output logic [31:0]                 bus_rdata_o,
  output logic                        irq_o
);
  localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);
  localparam int ENT_W   = $bits(ets_entry_t);
  localparam int MSK_BASE = 'h40;
  localparam int MSK_STEP = 'h20;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_TSH  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_TSL  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_PREV = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h20);

  logic rs1_q, rs2_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_core_n = rs2_q;

  logic             en_q, ien_q, ovf_q, ovf_d, ctrl_we, ovf_clr;
  logic [7:0]       thr_q, occ8;
  logic [TS_W-1:0]  tsc_q;
  logic [NUM_SLICES*LANES-1:0] mask_w;
  logic             push, drop, pop, f_full, f_empty;
  logic [ENT_W-1:0] f_dout;
  logic [CNT_W-1:0] f_cnt;
  ets_entry_t       cap_entry, head;

  assign ctrl_we = bus_wr_i && (bus_addr_i == A_CTRL);
  assign ovf_clr = bus_wr_i && (bus_addr_i == A_STAT) && bus_wdata_i[0];
  assign pop     = bus_wr_i && (bus_addr_i == A_CMD) && (bus_wdata_i == 32'd1);
  assign ovf_d   = drop ? 1'b1 : (ovf_clr ? 1'b0 : ovf_q);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      en_q  <= 1'b0;
      ien_q <= 1'b0;
      thr_q <= 8'd1;
      ovf_q <= 1'b0;
      tsc_q <= '0;
    end else begin
      tsc_q <= tsc_q + 1'b1;
      ovf_q <= ovf_d;
      if (ctrl_we) begin
        en_q  <= bus_wdata_i[0];
        ien_q <= bus_wdata_i[1];
        thr_q <= bus_wdata_i[15:8];
      end
    end
  end

  for (genvar n = 0; n < NUM_SLICES; n++) begin : g_mask
    logic [LANES-1:0] msk_q;
    logic             msk_we;
    assign msk_we = bus_wr_i && (bus_addr_i == ADDR_W'(MSK_BASE + n*MSK_STEP));
    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n)  msk_q <= '0;
      else if (msk_we)  msk_q <= bus_wdata_i;
    end
    assign mask_w[n*LANES +: LANES] = msk_q;
  end

  ets_capture #(.NUM_SLICES(NUM_SLICES)) u_cap (
    .clk(clk), .rst_n(rst_core_n), .glb_en_i(en_q), .lines_i(lines_i),
    .mask_i(mask_w), .ts_i(tsc_q), .full_i(f_full), .push_o(push),
    .drop_o(drop), .entry_o(cap_entry)
  );

  ets_fifo #(.DEPTH(FIFO_DEPTH), .W(ENT_W)) u_fifo (
    .clk(clk), .rst_n(rst_core_n), .push_i(push), .pop_i(pop),
    .din_i(cap_entry), .dout_o(f_dout), .count_o(f_cnt),
    .full_o(f_full), .empty_o(f_empty)
  );

  assign head  = f_empty ? '0 : ets_entry_t'(f_dout);
  assign occ8  = 8'(f_cnt);
  assign irq_o = en_q && ien_q && (occ8 >= thr_q);

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_CTRL: bus_rdata_o = {16'd0, thr_q, 6'd0, ien_q, en_q};
      A_TSH:  bus_rdata_o = head.ts[63:32];
      A_TSL:  bus_rdata_o = head.ts[31:0];
      A_SRC:  bus_rdata_o = {8'd0, head.sid, 16'd0};
      A_CUR:  bus_rdata_o = head.cur;
      A_PREV: bus_rdata_o = head.prev;
      A_STAT: bus_rdata_o = {16'd0, occ8, 7'd0, ovf_q};
      default: begin
        for (int i = 0; i < NUM_SLICES; i++) begin
          if (bus_addr_i == ADDR_W'(MSK_BASE + i*MSK_STEP))
            bus_rdata_o = mask_w[i*LANES +: LANES];
        end
      end
    endcase
  end

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
endmodule

// File: tb/tb_ets_engine.sv
module tb_ets_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] lines;
  logic [7:0]  addr;
  logic        wr;
  logic [31:0] wdata, rdata, rv, ta, tb2;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  ets_engine dut (
    .clk(clk), .rst_n(rst_n), .lines_i(lines), .bus_addr_i(addr),
    .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  localparam int NV = 6;
  localparam logic [63:0] V_LINES [NV] = '{
    64'h0000_0000_0000_0001, 64'h0000_0000_FFFF_0001, 64'h0000_0000_FFFF_00F0,
    64'h8000_0000_FFFF_00F0, 64'h8000_0001_FFFF_00F0, 64'h0000_0000_0000_00F0};
  localparam logic V_N [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [31:0] V_SRC [NV] = '{32'h0, 32'h0, 32'h0,
    32'h0001_0000, 32'h0001_0000, 32'h0001_0000};
  localparam logic [31:0] V_PREV [NV] = '{32'h0, 32'h0, 32'h1,
    32'h0, 32'h8000_0000, 32'h8000_0001};
  localparam logic [31:0] V_CUR [NV] = '{32'h1, 32'h0, 32'hF0,
    32'h8000_0000, 32'h8000_0001, 32'h0};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; lines = '0; addr = '0; wr = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_reg(8'h00, rv); check("R1 ctrl", rv, 32'h100);
    rd_reg(8'h20, rv); check("R1 status", rv, 32'h0);
    rd_reg(8'h40, rv); check("R1 mask0", rv, 32'h0);
    check("R1 irq", irq, 0);

    wr_reg(8'h40, 32'h0000_FFFF);
    wr_reg(8'h60, 32'hFFFF_FFFF);
    wr_reg(8'h00, 32'h0000_0001);

    // table walk: R2 latency, R3 mask, R5 head fields
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); lines = V_LINES[i];
      repeat (3) @(posedge clk);
      rd_reg(8'h20, rv); check("R2 occupancy before 4th edge", rv, 32'h0);
      @(posedge clk);
      rd_reg(8'h20, rv); check("R2/R3 occupancy", rv, {23'd0, V_N[i], 8'd0});
      if (V_N[i]) begin
        rd_reg(8'h0C, rv); check("R5 source", rv, V_SRC[i]);
        rd_reg(8'h14, rv); check("R3/R5 prev", rv, V_PREV[i]);
        rd_reg(8'h10, rv); check("R3/R5 cur", rv, V_CUR[i]);
        wr_reg(8'h1C, 32'd1);
        rd_reg(8'h20, rv); check("R8 pop", rv, 32'h0);
      end
    end

    // R6 two slices on one cycle
    @(negedge clk); lines = 64'h0000_0001_0000_0001;
    repeat (5) @(posedge clk);
    rd_reg(8'h20, rv); check("R6 occupancy", rv, 32'h200);
    rd_reg(8'h0C, rv); check("R6 first slice", rv, 32'h0);
    rd_reg(8'h14, rv); check("R6 prev slice0", rv, 32'hF0);
    rd_reg(8'h08, ta);
    wr_reg(8'h1C, 32'd1);
    rd_reg(8'h0C, rv); check("R6 second slice", rv, 32'h0001_0000);
    rd_reg(8'h08, tb2); check("R6 equal timestamps", tb2, ta);
    wr_reg(8'h1C, 32'd1);

    // R7 timestamp spacing, R8 ignored command value
    @(negedge clk); lines[33] = 1'b1;
    repeat (7) @(posedge clk);
    @(negedge clk); lines[33] = 1'b0;
    repeat (5) @(posedge clk);
    wr_reg(8'h1C, 32'd2);
    rd_reg(8'h20, rv); check("R8 non-one command", rv, 32'h200);
    rd_reg(8'h04, rv); check("R7 high word", rv, 32'h0);
    rd_reg(8'h08, ta);
    wr_reg(8'h1C, 32'd1);
    rd_reg(8'h08, tb2); check("R7 delta", tb2 - ta, 32'd7);
    wr_reg(8'h1C, 32'd1);

    // R11 interrupt threshold, R10 overflow
    wr_reg(8'h00, 32'h0000_0303);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); lines[32] = ~lines[32];
      repeat (4) @(posedge clk);
    end
    @(negedge clk); check("R11 irq below threshold", irq, 0);
    @(negedge clk); lines[32] = ~lines[32];
    repeat (4) @(posedge clk);
    @(negedge clk); check("R11 irq at threshold", irq, 1);
    for (int k = 0; k < 15; k++) begin
      @(negedge clk); lines[32] = ~lines[32];
      repeat (3) @(posedge clk);
    end
    repeat (4) @(posedge clk);
    rd_reg(8'h20, rv); check("R10 full with overflow", rv, 32'h1001);
    wr_reg(8'h00, 32'h0000_0301);
    @(negedge clk); check("R11 irq masked", irq, 0);
    wr_reg(8'h00, 32'h0000_0303);
    @(negedge clk); check("R11 irq restored", irq, 1);
    wr_reg(8'h20, 32'h0);
    rd_reg(8'h20, rv); check("R10 write zero keeps flag", rv, 32'h1001);
    wr_reg(8'h20, 32'h1);
    rd_reg(8'h20, rv); check("R10 clear flag", rv, 32'h1000);
    for (int k = 0; k < 16; k++) wr_reg(8'h1C, 32'd1);
    rd_reg(8'h20, rv); check("R8 drained", rv, 32'h0);
    @(negedge clk); check("R11 irq empty", irq, 0);
    wr_reg(8'h1C, 32'd1);
    rd_reg(8'h20, rv); check("R8 pop on empty", rv, 32'h0);
    rd_reg(8'h08, rv); check("R9 empty ts", rv, 32'h0);
    rd_reg(8'h0C, rv); check("R9 empty source", rv, 32'h0);
    rd_reg(8'h10, rv); check("R9 empty cur", rv, 32'h0);

    // R4 global enable off
    wr_reg(8'h00, 32'h0000_0300);
    @(negedge clk); lines[0] = ~lines[0];
    repeat (5) @(posedge clk);
    rd_reg(8'h20, rv); check("R4 disabled", rv, 32'h0);
    wr_reg(8'h00, 32'h0000_0301);
    repeat (5) @(posedge clk);
    rd_reg(8'h20, rv); check("R4 no stale event", rv, 32'h0);

    finish_run();
  end
endmodule